// File: doc/BRIEF.md
# I2C Expander Command Pointer Decoder

This block sits behind a byte-level I2C slave engine inside a multi-bank I/O expander. The engine reports each start or repeated start, each received byte, and each point in a read transfer where it needs the next byte to send. For every received byte the decoder returns an acknowledge decision one clock later. It recognises the device's own address and three special addresses. It captures the command byte that follows a write address, and it holds the register pointer and the auto-increment flag. It raises a write strobe for each accepted data byte and a read strobe each time the engine asks for read data.

Registers fall into two categories. The first holds five groups, each repeated across several banks. The second holds three single registers. The legal codes come from one base-code table. A command byte is accepted only when it names a legal code. Data written to the read-only input group is refused. With auto-increment on, the pointer moves through the banks and groups of its category and wraps back to the category's first register.

Top module: `i2cx_cmd_decoder`

## Requirements
- R1: After reset the pointer is 00h, auto_inc is 1, and no strobe is raised.
- R2: A byte is answered in the cycle after rx_vld: ack_vld is 1 and ack carries the decision. The own address (parameter, default 20h) is acknowledged for both R/W values (bit 0: 1 = read) and sets addr_kind 0. Any address that is not recognised is refused.
- R3: The all-call address 6Eh is acknowledged only with R/W = 0 (addr_kind 1). With R/W = 1 it is refused.
- R4: The alert response address 0Ch and the device-ID address 7Ch are acknowledged only with R/W = 1 (addr_kind 2 and 3). With R/W = 0 both are refused.
- R5: The first byte after an acknowledged write address is the command. It is acknowledged only if bit 6 is 0 and bits 5:0 name a legal code: 00h-04h, 08h-0Ch, 10h-14h, 18h-1Ch, 20h-24h, 28h, 29h or 2Ah. An accepted command loads bit 7 into auto_inc and bits 5:0 into ptr. A refused command leaves both unchanged.
- R6: A data byte aimed at the input group (00h-04h) is refused and raises no wr_stb. Every later byte of that transfer is also refused.
- R7: A data byte aimed at any other legal register is acknowledged. In the same cycle it raises wr_stb with wr_addr equal to the old pointer and wr_data equal to the byte.
- R8: With auto_inc set, each access moves the pointer to the next bank. The last bank of a group moves it to the next group's base (04h to 08h). 24h wraps to 00h.
- R9: Among the single registers, auto-increment goes 28h, 29h, 2Ah, then back to 28h. With auto_inc clear, the pointer holds.
- R10: A repeated start keeps the pointer. In a read transfer to the own address, each tx_req raises rd_stb with rd_addr equal to the pointer, then the pointer advances as in R8. tx_req outside such a transfer does nothing.
- R11: Bytes that arrive before any start, or after a refused byte and before the next start, are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start or repeated start seen on the bus |
| rx_vld | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Engine needs the next read byte |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| addr_kind | output | 2 | Address matched: 0 own, 1 all-call, 2 alert, 3 device-ID |
| ptr | output | 6 | Current register pointer |
| auto_inc | output | 1 | Auto-increment flag |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 6 | Register written |
| wr_data | output | 8 | Byte written |
| rd_stb | output | 1 | Register read strobe |
| rd_addr | output | 6 | Register read |

## Verification
If the transfer state is wrong, the symptom is an acknowledge decision of the wrong polarity. It shows at ack in the cycle after the very next byte, so the bench checks every decision. A wrong pointer or a wrong wrap step shows up at the next strobe as a wrong wr_addr or rd_addr. It shows up earlier as a wrong ptr value, which is visible on every cycle. A corrupted auto-increment flag shows as a pointer that holds when it should move, or moves when it should hold, one access later.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int NUM_GROUPS  = 5;
  localparam int NUM_SINGLES = 3;
  localparam int NUM_ENTRIES = NUM_GROUPS + NUM_SINGLES;

  typedef logic [5:0] base_tbl_t [NUM_ENTRIES];

  // groups first (input group at index 0), then singles
  localparam base_tbl_t DEF_BASE = '{6'h00, 6'h08, 6'h10, 6'h18, 6'h20,
                                     6'h28, 6'h29, 6'h2A};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_READ, ST_OTHER, ST_DROP
  } xfer_state_t;

  typedef enum logic [1:0] {
    KIND_OWN = 2'd0, KIND_ALL = 2'd1, KIND_ALERT = 2'd2, KIND_DEVID = 2'd3
  } addr_kind_t;
endpackage

// File: rtl/i2cx_addr_match.sv
module i2cx_addr_match
  import i2cx_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR   = 7'h20,
  parameter logic [6:0] ALL_ADDR   = 7'h6E,
  parameter logic [6:0] ALERT_ADDR = 7'h0C,
  parameter logic [6:0] DEVID_ADDR = 7'h7C
) (
  input  logic [7:0]  addr_byte,
  output logic        accept,
  output addr_kind_t  kind
);
  logic [6:0] a7;
  logic       is_rd;

  assign a7    = addr_byte[7:1];
  assign is_rd = addr_byte[0];

  always_comb begin
    accept = 1'b0;
    kind   = KIND_OWN;
    if (a7 == OWN_ADDR) begin
      accept = 1'b1;
    end else if (a7 == ALL_ADDR) begin
      accept = !is_rd;
      kind   = KIND_ALL;
    end else if (a7 == ALERT_ADDR) begin
      accept = is_rd;
      kind   = KIND_ALERT;
    end else if (a7 == DEVID_ADDR) begin
      accept = is_rd;
      kind   = KIND_DEVID;
    end
  end
endmodule

// File: rtl/i2cx_reg_map.sv
module i2cx_reg_map
  import i2cx_pkg::*;
#(
  parameter int        NUM_BANKS = 5,
  parameter base_tbl_t REG_BASE  = DEF_BASE
) (
  input  logic [6:0] code,
  output logic       legal,
  output logic       read_only,
  output logic [5:0] next_code
);
  localparam int LAST_G = NUM_GROUPS - 1;
  localparam int LAST_S = NUM_SINGLES - 1;

  logic [5:0] c6;
  assign c6 = code[5:0];

  always_comb begin
    legal     = 1'b0;
    read_only = 1'b0;
    next_code = c6;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(c6) >= int'(REG_BASE[g]) &&
          int'(c6) < int'(REG_BASE[g]) + NUM_BANKS) begin
        legal     = 1'b1;
        read_only = (g == 0);
        if (int'(c6) == int'(REG_BASE[g]) + NUM_BANKS - 1)
          next_code = REG_BASE[(g == LAST_G) ? 0 : g + 1];
        else
          next_code = c6 + 6'd1;
      end
    end
    for (int s = 0; s < NUM_SINGLES; s++) begin
      if (c6 == REG_BASE[NUM_GROUPS + s]) begin
        legal     = 1'b1;
        next_code = REG_BASE[NUM_GROUPS + ((s == LAST_S) ? 0 : s + 1)];
      end
    end
    if (code[6]) legal = 1'b0;
  end
endmodule

// File: rtl/i2cx_cmd_decoder.sv
module i2cx_cmd_decoder
  import i2cx_pkg::*;
#(
  parameter int         NUM_BANKS  = 5,
  parameter base_tbl_t  REG_BASE   = DEF_BASE,
  parameter logic [6:0] OWN_ADDR   = 7'h20,
  parameter logic [6:0] ALL_ADDR   = 7'h6E,
  parameter logic [6:0] ALERT_ADDR = 7'h0C,
  parameter logic [6:0] DEVID_ADDR = 7'h7C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_evt,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       ack_vld,
  output logic       ack,
  output logic [1:0] addr_kind,
  output logic [5:0] ptr,
  output logic       auto_inc,
  output logic       wr_stb,
  output logic [5:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_stb,
  output logic [5:0] rd_addr
);
  xfer_state_t state;
  addr_kind_t  a_kind;
  logic        a_ok;
  logic        in_legal, in_ro;
  logic [5:0]  in_next;
  logic        p_legal, p_ro;
  logic [5:0]  p_next;

  i2cx_addr_match #(
    .OWN_ADDR(OWN_ADDR), .ALL_ADDR(ALL_ADDR),
    .ALERT_ADDR(ALERT_ADDR), .DEVID_ADDR(DEVID_ADDR)
  ) i_addr (
    .addr_byte(rx_byte), .accept(a_ok), .kind(a_kind)
  );

  // decode of an incoming command byte
  i2cx_reg_map #(.NUM_BANKS(NUM_BANKS), .REG_BASE(REG_BASE)) i_map_in (
    .code(rx_byte[6:0]), .legal(in_legal), .read_only(in_ro), .next_code(in_next)
  );

  // decode of the held pointer
  i2cx_reg_map #(.NUM_BANKS(NUM_BANKS), .REG_BASE(REG_BASE)) i_map_ptr (
    .code({1'b0, ptr}), .legal(p_legal), .read_only(p_ro), .next_code(p_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_vld   <= 1'b0;
      ack       <= 1'b0;
      addr_kind <= KIND_OWN;
      ptr       <= 6'h00;
      auto_inc  <= 1'b1;
      wr_stb    <= 1'b0;
      wr_addr   <= 6'h00;
      wr_data   <= 8'h00;
      rd_stb    <= 1'b0;
      rd_addr   <= 6'h00;
    end else begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR;
      end else if (rx_vld) begin
        ack_vld <= 1'b1;
        unique case (state)
          ST_ADDR: begin
            ack       <= a_ok;
            addr_kind <= a_kind;
            if (!a_ok)                state <= ST_DROP;
            else if (rx_byte[0])      state <= (a_kind == KIND_OWN) ? ST_READ : ST_OTHER;
            else                      state <= ST_CMD;
          end
          ST_CMD: begin
            ack <= in_legal;
            if (in_legal) begin
              ptr      <= rx_byte[5:0];
              auto_inc <= rx_byte[7];
              state    <= ST_WDATA;
            end else begin
              state <= ST_DROP;
            end
          end
          ST_WDATA: begin
            if (p_ro || !p_legal) begin
              state <= ST_DROP;
            end else begin
              ack     <= 1'b1;
              wr_stb  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= rx_byte;
              if (auto_inc) ptr <= p_next;
            end
          end
          default: state <= (state == ST_IDLE) ? ST_IDLE : ST_DROP;
        endcase
      end else if (tx_req && state == ST_READ) begin
        rd_stb  <= 1'b1;
        rd_addr <= ptr;
        if (auto_inc) ptr <= p_next;
      end
    end
  end

  // R1: reset defaults
  p_reset_dflt_r1: assert property (@(posedge clk)
    rst |=> (ptr == 6'h00 && auto_inc && !wr_stb && !rd_stb));

  // R6: no write reaches the input group
  p_ro_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (int'(wr_addr) < int'(REG_BASE[0]) ||
                int'(wr_addr) >= int'(REG_BASE[0]) + NUM_BANKS));

  // R7: each write strobe comes with an acknowledge
  p_wr_acked_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (ack_vld && ack));

  // R8: the held pointer always names a legal register
  p_ptr_legal_r8: assert property (@(posedge clk) disable iff (rst)
    p_legal);

  // R9: with auto-increment off a write leaves the pointer in place
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !auto_inc) |-> (ptr == wr_addr));

  // R10: a start event never moves the pointer
  p_rs_keep_r10: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (ptr == $past(ptr)));
endmodule

// File: tb/test_i2cx_cmd_decoder.sv
module test_i2cx_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_evt = 1'b0, rx_vld = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ack_vld, ack, auto_inc, wr_stb, rd_stb;
  logic [1:0] addr_kind;
  logic [5:0] ptr, wr_addr, rd_addr;
  logic [7:0] wr_data;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  i2cx_cmd_decoder i_i2cx_cmd_decoder (
    .clk, .rst, .start_evt, .rx_vld, .rx_byte, .tx_req,
    .ack_vld, .ack, .addr_kind, .ptr, .auto_inc,
    .wr_stb, .wr_addr, .wr_data, .rd_stb, .rd_addr
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic send(string req, logic [7:0] b, logic exp_ack);
    @(negedge clk) begin rx_vld = 1'b1; rx_byte = b; end
    @(negedge clk) rx_vld = 1'b0;
    check({req, " ack_vld"}, ack_vld, 1);
    check({req, " ack"}, ack, exp_ack);
  endtask

  task automatic pull(string req, logic exp_stb, logic [5:0] exp_addr, logic [5:0] exp_ptr);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
    check({req, " rd_stb"}, rd_stb, exp_stb);
    if (exp_stb) check({req, " rd_addr"}, rd_addr, exp_addr);
    check({req, " ptr"}, ptr, exp_ptr);
  endtask

  task automatic wr_byte(string req, logic [7:0] d, logic [5:0] exp_addr, logic [5:0] exp_ptr);
    send(req, d, 1'b1);
    check({req, " wr_stb"}, wr_stb, 1);
    check({req, " wr_addr"}, wr_addr, exp_addr);
    check({req, " wr_data"}, wr_data, d);
    check({req, " ptr"}, ptr, exp_ptr);
  endtask

  task automatic t_reset();
    check("R1 ptr", ptr, 0);
    check("R1 auto_inc", auto_inc, 1);
    check("R1 wr_stb", wr_stb, 0);
    check("R1 rd_stb", rd_stb, 0);
    send("R11 no start", 8'h40, 1'b0);
  endtask

  task automatic t_addr();
    do_start(); send("R2 own write", 8'h40, 1'b1);
    check("R2 kind", addr_kind, 0);
    do_start(); send("R2 own read", 8'h41, 1'b1);
    do_start(); send("R2 unknown", 8'h52, 1'b0);
    send("R11 after nack", 8'h00, 1'b0);
  endtask

  task automatic t_special();
    do_start(); send("R3 allcall write", 8'hDC, 1'b1);
    check("R3 kind", addr_kind, 1);
    do_start(); send("R3 allcall read", 8'hDD, 1'b0);
    do_start(); send("R4 alert read", 8'h19, 1'b1);
    check("R4 alert kind", addr_kind, 2);
    do_start(); send("R4 alert write", 8'h18, 1'b0);
    do_start(); send("R4 devid read", 8'hF9, 1'b1);
    check("R4 devid kind", addr_kind, 3);
    do_start(); send("R4 devid write", 8'hF8, 1'b0);
  endtask

  task automatic t_cmd();
    do_start(); send("R5 addr", 8'h40, 1'b1);
    send("R5 cmd 2Bh", 8'h2B, 1'b0);
    check("R5 ptr kept", ptr, 0);
    check("R5 ai kept", auto_inc, 1);
    do_start(); send("R5 addr", 8'h40, 1'b1);
    send("R5 cmd bit6", 8'h45, 1'b0);
    check("R5 ptr kept", ptr, 0);
    do_start(); send("R5 addr", 8'h40, 1'b1);
    send("R5 cmd 06h", 8'h06, 1'b0);
    do_start(); send("R5 addr", 8'h40, 1'b1);
    send("R5 cmd 0Ch", 8'h0C, 1'b1);
    check("R5 ptr load", ptr, 6'h0C);
    check("R5 ai load", auto_inc, 0);
  endtask

  task automatic t_write();
    do_start(); send("R6 addr", 8'h40, 1'b1);
    send("R6 cmd 83h", 8'h83, 1'b1);
    send("R6 data to input", 8'h55, 1'b0);
    check("R6 no wr_stb", wr_stb, 0);
    send("R6 rest refused", 8'h66, 1'b0);
    do_start(); send("R7 addr", 8'h40, 1'b1);
    send("R7 cmd 8Bh", 8'h8B, 1'b1);
    wr_byte("R7 write 0Bh", 8'hA5, 6'h0B, 6'h0C);
    wr_byte("R8 bank end", 8'h3C, 6'h0C, 6'h10);
    do_start(); send("R8 addr", 8'h40, 1'b1);
    send("R8 cmd A4h", 8'hA4, 1'b1);
    wr_byte("R8 wrap 24h", 8'h11, 6'h24, 6'h00);
    send("R8 wrapped into input", 8'h22, 1'b0);
    do_start(); send("R7 allcall", 8'hDC, 1'b1);
    send("R7 cmd 98h", 8'h98, 1'b1);
    wr_byte("R7 allcall write", 8'h77, 6'h18, 6'h19);
  endtask

  task automatic t_single();
    do_start(); send("R9 addr", 8'h40, 1'b1);
    send("R9 cmd A9h", 8'hA9, 1'b1);
    wr_byte("R9 29h", 8'h01, 6'h29, 6'h2A);
    wr_byte("R9 2Ah wrap", 8'h02, 6'h2A, 6'h28);
    do_start(); send("R9 addr", 8'h40, 1'b1);
    send("R9 cmd 29h no ai", 8'h29, 1'b1);
    wr_byte("R9 hold 1", 8'h03, 6'h29, 6'h29);
    wr_byte("R9 hold 2", 8'h04, 6'h29, 6'h29);
  endtask

  task automatic t_read();
    do_start(); send("R10 addr", 8'h40, 1'b1);
    send("R10 cmd 82h", 8'h82, 1'b1);
    pull("R10 tx_req in write", 1'b0, 6'h00, 6'h02);
    do_start();
    check("R10 ptr after rs", ptr, 6'h02);
    send("R10 read addr", 8'h41, 1'b1);
    pull("R10 read 02h", 1'b1, 6'h02, 6'h03);
    pull("R10 read 03h", 1'b1, 6'h03, 6'h04);
    pull("R8 read 04h", 1'b1, 6'h04, 6'h08);
    do_start(); send("R10 alert", 8'h19, 1'b1);
    pull("R10 tx_req in alert", 1'b0, 6'h00, 6'h08);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr();
        t_special();
        t_cmd();
        t_write();
        t_single();
        t_read();
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule